// File: doc/BRIEF.md
# Eight-Register Multicycle Word Processor Core

This block is a compact 32-bit processor core that executes an eight-opcode instruction set from one word-addressed memory shared by code and data. It holds eight general-purpose 32-bit registers, a program counter, a retired-instruction counter and a stop flag. The operations are register addition and NAND, loads and stores with base-plus-offset addressing, a branch taken on register equality, a no-operation and a stop instruction.

While reset is held low, the environment fills memory through a dedicated write port. Releasing reset starts execution at word 0. The core then steps through a multicycle sequence of named states. In ST_FETCH it issues a synchronous read at the PC. In ST_DECODE it latches the instruction word. In ST_EXEC it computes and commits the result. For loads only, it passes through ST_LDWB, where the returned memory word is written back to a register. After executing a halt it parks in ST_STOP. The transitions are ST_FETCH→ST_DECODE→ST_EXEC→ST_FETCH for every instruction except two. A load takes ST_EXEC→ST_LDWB→ST_FETCH, and a halt takes ST_EXEC→ST_STOP. ST_STOP is left only through reset.

The register file can be read through a side port, and the PC, counter and flags are driven as outputs, so results are visible without looking inside the core.

Top module: `wcore_top`

## Requirements
- R1: While reset is low and on release, the PC, the retired count, every register, the halted flag and the illegal flag all read 0.
- R2: Opcode 000 (bits 24..22) writes A+B, modulo 2^32, into the register named by bits 2..0. A is the register named by bits 21..19 and B is the register named by bits 18..16.
- R3: Opcode 001 writes the bitwise NAND of A and B into the register named by bits 2..0.
- R4: Opcode 010 loads the register named by bits 18..16 from memory. The address is A plus the sign-extended 16-bit offset in bits 15..0, so negative offsets work.
- R5: Opcode 011 stores the register named by bits 18..16 to memory at A plus the sign-extended offset. A later load from that address returns the stored value.
- R6: Opcode 100 sets the next PC to PC+1+offset when A equals B, and to PC+1 otherwise.
- R7: Opcode 110 advances the PC by one and then raises halted. Afterwards the PC, the retired count and the registers stay frozen until reset.
- R8: The retired count rises by one per completed instruction, halt included. The countdown program 8454151, 9043971, 655361, 16842754, 16842749, 29360128, 25165824, 5, -1, 2 stops with count 17, register 1 = 0, register 2 = -1 and PC = 7.
- R9: Opcode 101 only advances the PC and sets a sticky illegal flag. Programs without that opcode leave the flag at 0.
- R10: Register 0 is writable like any other register.
- R11: Effective addresses and branch targets wrap modulo the memory depth 2^ADDR_W.
- R12: Opcode 111 only advances the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; core idles while low |
| ld_en | input | 1 | Preload write strobe |
| ld_addr | input | ADDR_W | Preload word address |
| ld_data | input | 32 | Preload word |
| dbg_sel | input | 3 | Register index for the side read port |
| dbg_data | output | 32 | Contents of the selected register |
| pc_out | output | ADDR_W | Program counter |
| retired | output | CNT_W | Completed-instruction count |
| halted | output | 1 | Stop instruction executed |
| illegal_op | output | 1 | Sticky flag: reserved opcode seen |

## Verification
A fault in the sequencer or the datapath shows up at the ports by the next instruction boundary. A wrong PC update changes which instructions run, so the retired count and the final register values at halt diverge from the hand-computed program results. A lost or doubled retire step shifts the count by the end of the program. A bad offset sign or address wrap leaves the wrong data in the destination register, which the side port reads after the stop. A stop state that fails to freeze is seen within a few cycles as PC or count drift.

// File: rtl/wcore_pkg.sv
package wcore_pkg;

    localparam int WORD_W    = 32;
    localparam int REG_COUNT = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_NAND = 3'b001,
        OP_LW   = 3'b010,
        OP_SW   = 3'b011,
        OP_BEQ  = 3'b100,
        OP_RSVD = 3'b101,
        OP_HALT = 3'b110,
        OP_NOOP = 3'b111
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_LDWB,
        ST_STOP
    } state_e;

endpackage

// File: rtl/wcore_regfile.sv
module wcore_regfile #(
    parameter int NREG  = 8,
    parameter int WIDTH = 32,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [WIDTH-1:0] wdata,
    input  logic [SEL_W-1:0] asel,
    output logic [WIDTH-1:0] adata,
    input  logic [SEL_W-1:0] bsel,
    output logic [WIDTH-1:0] bdata,
    input  logic [SEL_W-1:0] dsel,
    output logic [WIDTH-1:0] ddata
);

    logic [WIDTH-1:0] regs_q [NREG];

    // No entry is hardwired; register 0 is ordinary storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we) begin
            regs_q[wsel] <= wdata;
        end
    end

    assign adata = regs_q[asel];
    assign bdata = regs_q[bsel];
    assign ddata = regs_q[dsel];

endmodule

// File: rtl/wcore_mem.sv
module wcore_mem #(
    parameter int ADDR_W = 10,
    parameter int WIDTH  = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] store_q [DEPTH];

    // Synchronous read: data appears one cycle after the address.
    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
        rdata <= store_q[raddr];
    end

endmodule

// File: rtl/wcore_alu.sv
module wcore_alu #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             nand_sel,
    output logic [WIDTH-1:0] res,
    output logic             eq
);

    assign res = nand_sel ? ~(a & b) : (a + b);
    assign eq  = (a == b);

endmodule

// File: rtl/wcore_top.sv
module wcore_top
    import wcore_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    input  logic [2:0]        dbg_sel,
    output logic [31:0]       dbg_data,
    output logic [ADDR_W-1:0] pc_out,
    output logic [CNT_W-1:0]  retired,
    output logic              halted,
    output logic              illegal_op
);

    localparam int SEL_W = $clog2(REG_COUNT);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d, pc_inc, br_tgt, ea, mem_raddr;
    logic [WORD_W-1:0] ir_q, mem_rdata, rf_a, rf_b, rf_wdata, alu_res;
    logic [WORD_W-1:0] off32, ea_full;
    logic [CNT_W-1:0]  ret_q;
    logic              halt_q, ill_q;
    logic              ir_ld, mem_we, rf_we, retire, set_halt, set_ill, alu_eq;
    logic [SEL_W-1:0]  rf_wsel;
    opcode_e           opc;
    logic              unused_bits;

    assign opc     = opcode_e'(ir_q[24:22]);
    assign off32   = {{16{ir_q[15]}}, ir_q[15:0]};
    assign ea_full = rf_a + off32;
    assign ea      = ea_full[ADDR_W-1:0];
    assign pc_inc  = pc_q + 1'b1;
    assign br_tgt  = pc_inc + off32[ADDR_W-1:0];
    assign unused_bits = ^{ir_q[31:25], ea_full[WORD_W-1:ADDR_W]};

    wcore_regfile #(.NREG(REG_COUNT), .WIDTH(WORD_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wsel  (rf_wsel),
        .wdata (rf_wdata),
        .asel  (ir_q[21:19]),
        .adata (rf_a),
        .bsel  (ir_q[18:16]),
        .bdata (rf_b),
        .dsel  (dbg_sel),
        .ddata (dbg_data)
    );

    wcore_mem #(.ADDR_W(ADDR_W), .WIDTH(WORD_W)) u_mem (
        .clk   (clk),
        .we    (ld_en | mem_we),
        .waddr (ld_en ? ld_addr : ea),
        .wdata (ld_en ? ld_data : rf_b),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    wcore_alu #(.WIDTH(WORD_W)) u_alu (
        .a        (rf_a),
        .b        (rf_b),
        .nand_sel (opc == OP_NAND),
        .res      (alu_res),
        .eq       (alu_eq)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        mem_raddr = pc_q;
        mem_we    = 1'b0;
        rf_we     = 1'b0;
        rf_wsel   = ir_q[2:0];
        rf_wdata  = alu_res;
        pc_d      = pc_q;
        ir_ld     = 1'b0;
        retire    = 1'b0;
        set_halt  = 1'b0;
        set_ill   = 1'b0;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                ir_ld   = 1'b1;
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                pc_d    = pc_inc;
                retire  = 1'b1;
                state_d = ST_FETCH;
                unique case (opc)
                    OP_ADD, OP_NAND: rf_we = 1'b1;
                    OP_LW: begin
                        mem_raddr = ea;
                        retire    = 1'b0;
                        state_d   = ST_LDWB;
                    end
                    OP_SW:   mem_we = 1'b1;
                    OP_BEQ:  if (alu_eq) pc_d = br_tgt;
                    OP_RSVD: set_ill = 1'b1;
                    OP_HALT: begin
                        set_halt = 1'b1;
                        state_d  = ST_STOP;
                    end
                    OP_NOOP: ;
                endcase
            end
            ST_LDWB: begin
                rf_we    = 1'b1;
                rf_wsel  = ir_q[18:16];
                rf_wdata = mem_rdata;
                retire   = 1'b1;
                state_d  = ST_FETCH;
            end
            ST_STOP: ;
            default: state_d = ST_FETCH;
        endcase
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ir_q   <= '0;
            ret_q  <= '0;
            halt_q <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            pc_q <= pc_d;
            if (ir_ld)    ir_q   <= mem_rdata;
            if (retire)   ret_q  <= ret_q + 1'b1;
            if (set_halt) halt_q <= 1'b1;
            if (set_ill)  ill_q  <= 1'b1;
        end
    end

    assign pc_out     = pc_q;
    assign retired    = ret_q;
    assign halted     = halt_q;
    assign illegal_op = ill_q;

endmodule

// File: rtl/wcore_chk.sv
module wcore_chk #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc_out,
    input logic [CNT_W-1:0]  retired,
    input logic              halted,
    input logic              illegal_op
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (pc_out == '0 && retired == '0 && !halted && !illegal_op)); // R1
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R7
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) halted |=> ($stable(pc_out) && $stable(retired))); // R7
    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n) !halted |=> (retired == $past(retired) || retired == $past(retired) + 1'b1)); // R8
    AST_HALT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n) $rose(halted) |-> (retired == $past(retired) + 1'b1)); // R8
    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) illegal_op |=> illegal_op); // R9

endmodule

bind wcore_top wcore_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_out     (pc_out),
    .retired    (retired),
    .halted     (halted),
    .illegal_op (illegal_op)
);

// File: tb/tb_wcore_top.sv
`timescale 1ns/1ps
module tb_wcore_top;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [2:0]    dbg_sel = '0;
    logic [31:0]   dbg_data;
    logic [AW-1:0] pc_out;
    logic [31:0]   retired;
    logic          halted;
    logic          illegal_op;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    wcore_top #(.ADDR_W(AW), .CNT_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .pc_out(pc_out), .retired(retired), .halted(halted),
        .illegal_op(illegal_op)
    );

    function automatic logic [31:0] enc_r(int op, int a, int b, int d);
        return (32'(op) << 22) | (32'(a) << 19) | (32'(b) << 16) | 32'(d);
    endfunction

    function automatic logic [31:0] enc_i(int op, int a, int b, int off);
        return (32'(op) << 22) | (32'(a) << 19) | (32'(b) << 16) | (32'(off) & 32'h0000FFFF);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic poke(int addr, logic [31:0] data);
        ld_en   = 1'b1;
        ld_addr = AW'(addr);
        ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic release_and_run();
        rst_n = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        if (!halted) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 run did not halt: actual 0 expected 1");
        end
    endtask

    task automatic get_reg(int idx, output logic [31:0] v);
        dbg_sel = 3'(idx);
        #1;
        v = dbg_data;
    endtask

    // R8, R7, R9, R6: countdown loop with backward branch
    task automatic t_countdown();
        logic [31:0] v;
        hold_reset();
        poke(0, 32'd8454151);  poke(1, 32'd9043971);  poke(2, 32'd655361);
        poke(3, 32'd16842754); poke(4, 32'd16842749); poke(5, 32'd29360128);
        poke(6, 32'd25165824); poke(7, 32'd5);        poke(8, 32'hFFFFFFFF);
        poke(9, 32'd2);
        release_and_run();
        check("R8", "countdown retired", retired, 32'd17);
        check("R8", "countdown pc", 32'(pc_out), 32'd7);
        get_reg(1, v); check("R8", "countdown reg1", v, 32'd0);
        get_reg(2, v); check("R8", "countdown reg2", v, 32'hFFFFFFFF);
        check("R9", "illegal flag clean program", 32'(illegal_op), 32'd0);
        repeat (12) @(negedge clk);
        check("R7", "pc frozen after halt", 32'(pc_out), 32'd7);
        check("R7", "retired frozen after halt", retired, 32'd17);
        check("R7", "halted held", 32'(halted), 32'd1);
        get_reg(2, v); check("R7", "reg2 frozen", v, 32'hFFFFFFFF);
    endtask

    // R2, R3, R10
    task automatic t_alu();
        logic [31:0] v;
        hold_reset();
        poke(0, enc_i(2, 0, 1, 10));
        poke(1, enc_i(2, 0, 2, 11));
        poke(2, enc_r(0, 1, 2, 3));
        poke(3, enc_r(1, 1, 2, 4));
        poke(4, enc_r(0, 1, 2, 0));
        poke(5, enc_r(6, 0, 0, 0));
        poke(10, 32'h7FFFFFFF);
        poke(11, 32'h00000001);
        release_and_run();
        get_reg(3, v); check("R2", "add overflow wrap", v, 32'h80000000);
        get_reg(4, v); check("R3", "nand result", v, 32'hFFFFFFFE);
        get_reg(0, v); check("R10", "reg0 written", v, 32'h80000000);
        check("R8", "alu retired", retired, 32'd6);
        check("R7", "alu pc past halt", 32'(pc_out), 32'd6);
    endtask

    // R4, R5, R11
    task automatic t_mem();
        logic [31:0] v;
        hold_reset();
        poke(0, enc_i(2, 0, 1, 20));
        poke(1, enc_i(2, 1, 2, -3));
        poke(2, enc_i(3, 1, 2, 5));
        poke(3, enc_i(2, 0, 3, 30));
        poke(4, enc_i(2, 0, 4, -1));
        poke(5, enc_r(6, 0, 0, 0));
        poke(20, 32'd25);
        poke(22, 32'hDEADBEEF);
        poke(30, 32'h0);
        poke(1023, 32'h12345678);
        release_and_run();
        get_reg(2, v); check("R4", "load negative offset", v, 32'hDEADBEEF);
        get_reg(3, v); check("R5", "store then load", v, 32'hDEADBEEF);
        get_reg(4, v); check("R11", "load address wraps", v, 32'h12345678);
        check("R8", "mem retired", retired, 32'd6);
    endtask

    // R6, R12
    task automatic t_branch();
        logic [31:0] v;
        hold_reset();
        poke(0, enc_i(2, 0, 1, 20));
        poke(1, enc_i(4, 0, 1, 5));
        poke(2, enc_r(7, 0, 0, 0));
        poke(3, enc_i(4, 1, 1, 2));
        poke(4, enc_r(6, 0, 0, 0));
        poke(5, enc_r(6, 0, 0, 0));
        poke(6, enc_i(2, 0, 2, 21));
        poke(7, enc_r(6, 0, 0, 0));
        poke(20, 32'd7);
        poke(21, 32'd9);
        release_and_run();
        check("R6", "branch path retired", retired, 32'd6);
        check("R6", "branch final pc", 32'(pc_out), 32'd8);
        get_reg(2, v); check("R6", "taken branch target reached", v, 32'd9);
        get_reg(1, v); check("R12", "noop leaves regs", v, 32'd7);
    endtask

    // R11: branch target wraps below zero
    task automatic t_wrap_branch();
        hold_reset();
        poke(0, enc_i(4, 0, 0, -2));
        poke(1023, enc_r(6, 0, 0, 0));
        release_and_run();
        check("R11", "wrapped branch retired", retired, 32'd2);
        check("R11", "pc wraps past top", 32'(pc_out), 32'd0);
    endtask

    // R9
    task automatic t_illegal();
        logic [31:0] v;
        hold_reset();
        poke(0, enc_i(2, 0, 1, 5));
        poke(1, enc_r(5, 1, 1, 1));
        poke(2, enc_r(6, 0, 0, 0));
        poke(5, 32'd44);
        release_and_run();
        check("R9", "illegal flag set", 32'(illegal_op), 32'd1);
        check("R9", "reserved op advances pc", 32'(pc_out), 32'd3);
        check("R9", "reserved op retired", retired, 32'd3);
        get_reg(1, v); check("R9", "reserved op no write", v, 32'd44);
    endtask

    // R1
    task automatic t_reset();
        logic [31:0] v;
        hold_reset();
        check("R1", "pc reset", 32'(pc_out), 32'd0);
        check("R1", "retired reset", retired, 32'd0);
        check("R1", "halted reset", 32'(halted), 32'd0);
        check("R1", "illegal reset", 32'(illegal_op), 32'd0);
        for (int r = 0; r < 8; r++) begin
            get_reg(r, v);
            check("R1", "register reset", v, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_countdown();
        t_alu();
        t_mem();
        t_branch();
        t_wrap_branch();
        t_illegal();
        t_reset();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule